// File: doc/BRIEF.md
# External Bus Address Strobe Stretcher

This block times the address strobe of an external memory bus. The external address space is split into a lower half and an upper half by the most significant bit of the 22-bit access address. Each half has its own 2-bit stretch field in a small configuration register. A start request selects the field for the addressed half and latches its value. The block then holds the strobe for one base system clock plus that many extra wait clocks. In the clock after the strobe falls, it gives a one-cycle done pulse.

The same configuration register holds an enable bit for the external interface. While that bit is clear, a start request is refused: the block raises a one-cycle error pulse and drives no strobe. The stretch value is captured when an access starts. A register write made while the access is running therefore takes effect from the next access onward.

Top module: `strb_extbus_strobe`

## Requirements
- R1: After reset, cfg_rdata reads 0x0F, and strobe, done and err are 0. Both stretch fields therefore start at 3 and the enable bit (bit 4) at 0.
- R2: A write with cfg_we stores cfg_wdata bits 6:0, visible on cfg_rdata in the next cycle. Bit 7 always reads 0, whatever value is written to it.
- R3: When addr bit 21 is 0, the stretch count N is taken from register bits 3:2.
- R4: When addr bit 21 is 1, the stretch count N is taken from register bits 1:0.
- R5: A request accepted while idle with bit 4 set raises strobe in the next cycle. Strobe stays high for exactly 1+N consecutive cycles.
- R6: done is high for exactly one cycle, the cycle right after strobe falls, and never while strobe is high.
- R7: A request made while idle with bit 4 clear raises err for one cycle in the next cycle. No strobe is driven for that request.
- R8: A request held high while strobe or done is active has no effect: the running access keeps its length and no error is raised.
- R9: A register write during an access does not change the length of that access. The next access uses the new value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg_we | input | 1 | Configuration register write enable |
| cfg_wdata | input | 8 | Configuration write data |
| cfg_rdata | output | 8 | Configuration register contents |
| req | input | 1 | Access start request |
| addr | input | 22 | Access address; bit 21 selects the half |
| strobe | output | 1 | Stretched address strobe |
| done | output | 1 | One-cycle completion pulse |
| err | output | 1 | One-cycle pulse for a request refused while disabled |

## Verification
The bench builds the block with its default parameters: a 22-bit address, 2-bit stretch fields and a one-clock base period. With these values every stretch count from 0 to 3 can be reached in both address halves, including the reset maximum. Random register values and addresses from a fixed seed cover the field-select mapping. Directed cases cover the disabled-request error, requests held during a busy access, and a register rewrite in the middle of a strobe.

// File: rtl/strb_pkg.sv
package strb_pkg;
  // register field positions; the two stretch fields are decoded by the selector
  localparam int RSV_BIT  = 7;
  localparam int EN_BIT   = 4;
  localparam int LO_LSB   = 2;
  localparam int HI_LSB   = 0;
  localparam logic [7:0] CFG_RST = 8'h0F;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_HOLD = 2'd1,
    ST_DONE = 2'd2
  } strb_state_e;
endpackage

// File: rtl/strb_cfg_reg.sv
module strb_cfg_reg
  import strb_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       we,
  input  logic [7:0] wdata,
  output logic [7:0] rdata
);
  logic [6:0] bits_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) bits_q <= CFG_RST[6:0];
    else if (we) bits_q <= wdata[6:0];
  end

  // reserved top bit is not stored
  assign rdata = {1'b0, bits_q};
endmodule

// File: rtl/strb_stretch_pick.sv
module strb_stretch_pick
  import strb_pkg::*;
#(
  parameter int ADDR_W = 22,
  parameter int SW     = 2
) (
  input  logic [7:0]        cfg,
  input  logic [ADDR_W-1:0] addr,
  output logic [SW-1:0]     n_sel
);
  function automatic logic [SW-1:0] pick(input logic [7:0] c, input logic upper);
    return upper ? c[HI_LSB +: SW] : c[LO_LSB +: SW];
  endfunction

  assign n_sel = pick(cfg, addr[ADDR_W-1]);
endmodule

// File: rtl/strb_timer.sv
module strb_timer
  import strb_pkg::*;
#(
  parameter int SW       = 2,
  parameter int BASE_CYC = 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          req,
  input  logic          enable,
  input  logic [SW-1:0] n_sel,
  output logic          strobe,
  output logic          done,
  output logic          err,
  output logic          accept,
  output logic          refuse,
  output logic [SW-1:0] lat_n
);
  localparam int MAXLEN = BASE_CYC + (1 << SW) - 1;
  localparam int CNT_W  = $clog2(MAXLEN + 1) + 1;

  function automatic logic [CNT_W-1:0] hold_left(input logic [SW-1:0] n);
    return CNT_W'(BASE_CYC - 1) + CNT_W'(n);
  endfunction

  strb_state_e st_q;
  logic [CNT_W-1:0] cnt_q;
  logic err_q;

  assign accept = (st_q == ST_IDLE) && req && enable;
  assign refuse = (st_q == ST_IDLE) && req && !enable;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q  <= ST_IDLE;
      cnt_q <= '0;
      lat_n <= '0;
      err_q <= 1'b0;
    end else begin
      err_q <= refuse;
      case (st_q)
        ST_IDLE: if (accept) begin
          st_q  <= ST_HOLD;
          lat_n <= n_sel;
          cnt_q <= hold_left(n_sel);
        end
        ST_HOLD: begin
          if (cnt_q == '0) st_q <= ST_DONE;
          else cnt_q <= cnt_q - 1'b1;
        end
        default: st_q <= ST_IDLE;
      endcase
    end
  end

  assign strobe = (st_q == ST_HOLD);
  assign done   = (st_q == ST_DONE);
  assign err    = err_q;
endmodule

// File: rtl/strb_extbus_strobe.sv
module strb_extbus_strobe
  import strb_pkg::*;
#(
  parameter int ADDR_W   = 22,
  parameter int SW       = 2,
  parameter int BASE_CYC = 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_we,
  input  logic [7:0]        cfg_wdata,
  output logic [7:0]        cfg_rdata,
  input  logic              req,
  input  logic [ADDR_W-1:0] addr,
  output logic              strobe,
  output logic              done,
  output logic              err
);
  logic [SW-1:0] n_sel;
  logic [SW-1:0] lat_n;
  logic          accept;
  logic          refuse;

  strb_cfg_reg u_cfg (
    .clk(clk), .rst_n(rst_n), .we(cfg_we), .wdata(cfg_wdata), .rdata(cfg_rdata)
  );

  strb_stretch_pick #(.ADDR_W(ADDR_W), .SW(SW)) u_pick (
    .cfg(cfg_rdata), .addr(addr), .n_sel(n_sel)
  );

  strb_timer #(.SW(SW), .BASE_CYC(BASE_CYC)) u_tmr (
    .clk(clk), .rst_n(rst_n), .req(req), .enable(cfg_rdata[EN_BIT]),
    .n_sel(n_sel), .strobe(strobe), .done(done), .err(err),
    .accept(accept), .refuse(refuse), .lat_n(lat_n)
  );
endmodule

// File: rtl/strb_extbus_strobe_chk.sv
module strb_extbus_strobe_chk #(
  parameter int SW       = 2,
  parameter int BASE_CYC = 1
) (
  input logic          clk,
  input logic          rst_n,
  input logic          cfg_we,
  input logic [7:0]    cfg_wdata,
  input logic [7:0]    cfg_rdata,
  input logic          req,
  input logic          strobe,
  input logic          done,
  input logic          err,
  input logic          accept,
  input logic [SW-1:0] lat_n
);
  logic [7:0] runlen;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) runlen <= '0;
    else runlen <= strobe ? runlen + 8'd1 : 8'd0;
  end

  // R2
  cfg_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_we |=> (cfg_rdata[6:0] == $past(cfg_wdata[6:0])));

  // R5
  strobe_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
    accept |=> strobe);

  // R5
  strobe_len_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!strobe && $past(strobe)) |-> (runlen == 8'(BASE_CYC) + 8'(lat_n)));

  // R6
  done_after_strobe_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(strobe) |-> done);

  // R6
  done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done && !strobe);

  // R7
  err_no_strobe_chk: assert property (@(posedge clk) disable iff (!rst_n)
    err |-> !strobe && $past(req));
endmodule

bind strb_extbus_strobe strb_extbus_strobe_chk #(.SW(SW), .BASE_CYC(BASE_CYC)) u_chk (
  .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_wdata(cfg_wdata),
  .cfg_rdata(cfg_rdata), .req(req), .strobe(strobe), .done(done), .err(err),
  .accept(accept), .lat_n(lat_n)
);

// File: tb/strb_extbus_strobe_test.sv
module strb_extbus_strobe_test;
  logic clk = 0, rst_n = 0, cfg_we = 0, req = 0;
  logic [7:0] cfg_wdata = 0;
  logic [21:0] addr = 0;
  logic [7:0] cfg_rdata;
  logic strobe, done, err;
  int checks = 0, errors = 0;
  logic [7:0] model = 8'h0F;

  always #5 clk = ~clk;

  strb_extbus_strobe uut (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_wdata(cfg_wdata),
    .cfg_rdata(cfg_rdata), .req(req), .addr(addr), .strobe(strobe),
    .done(done), .err(err)
  );

  function automatic int exp_len(input logic [7:0] c, input logic [21:0] a);
    int n;
    n = a[21] ? int'(c[1:0]) : int'(c[3:2]);
    return 1 + n;
  endfunction

  task automatic chk(input string req_tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req_tag, act, exp);
    end
  endtask

  task automatic wr(input logic [7:0] d);
    @(negedge clk);
    cfg_we = 1; cfg_wdata = d;
    @(negedge clk);
    cfg_we = 0;
    model = d & 8'h7F;
    chk("R2 readback", cfg_rdata, model);
  endtask

  // one access; hold_req keeps req high while busy, mid_wr rewrites cfg in the strobe
  task automatic access(input logic [21:0] a, input bit hold_req, input bit mid_wr,
                        input logic [7:0] mid_val, input string tag);
    int len, exp;
    exp = exp_len(model, a);
    @(negedge clk);
    req = 1; addr = a;
    @(negedge clk);
    if (!hold_req) req = 0;
    chk({tag, " strobe rise"}, strobe, 1);
    len = 0;
    for (int i = 0; i < 12; i++) begin
      if (!strobe) break;
      len++;
      if (mid_wr && i == 0) begin cfg_we = 1; cfg_wdata = mid_val; end
      else cfg_we = 0;
      @(negedge clk);
    end
    cfg_we = 0;
    if (mid_wr) model = mid_val & 8'h7F;
    req = 0;
    chk({tag, " strobe length"}, len, exp);
    chk("R6 done after strobe", done, 1);
    chk("R8 no err while busy", err, 0);
    @(negedge clk);
    chk("R6 done single", done, 0);
    chk("R6 idle", strobe, 0);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL watchdog actual=hung expected=finish");
    $display("  Result: errors=%0d of %0d checks", errors, checks + 1);
    $finish;
  end

  initial begin
    void'($urandom(32'd4242));
    repeat (2) @(negedge clk);
    chk("R1 cfg reset", cfg_rdata, 8'h0F);
    chk("R1 strobe", strobe, 0);
    chk("R1 done", done, 0);
    chk("R1 err", err, 0);
    rst_n = 1;
    @(negedge clk);
    // R7: refused while disabled
    req = 1; addr = 22'h000123;
    @(negedge clk);
    req = 0;
    chk("R7 err pulse", err, 1);
    chk("R7 no strobe", strobe, 0);
    @(negedge clk);
    chk("R7 err single", err, 0);
    chk("R7 still no strobe", strobe, 0);
    // R2: bit 7 ignored
    wr(8'hFF);
    chk("R2 bit7 zero", cfg_rdata[7], 0);
    // R3 / R4 directed: lower=3 upper=0, then lower=0 upper=2
    wr(8'h1C);
    access(22'h0ABCDE, 0, 0, 0, "R3 lower n3");
    access(22'h2ABCDE, 0, 0, 0, "R4 upper n0");
    wr(8'h12);
    access(22'h000000, 0, 0, 0, "R3 lower n0");
    access(22'h3FFFFF, 0, 0, 0, "R4 upper n2");
    // R8: request held through busy
    access(22'h3FFFFF, 1, 0, 0, "R8 held req");
    // R9: mid-access rewrite shortens nothing, next access uses new value
    wr(8'h1F);
    access(22'h001000, 0, 1, 8'h10, "R9 mid write");
    access(22'h001000, 0, 0, 0, "R9 new value");
    // random
    for (int k = 0; k < 40; k++) begin
      logic [7:0] v;
      logic [21:0] a;
      v = 8'($urandom) | 8'h10;
      a = 22'($urandom);
      wr(v);
      access(a, 1'($urandom), 0, 0, a[21] ? "R4 random" : "R3 random");
    end
    $display("  Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule